// File: doc/BRIEF.md
# Double-Buffered Four-Pair PWM Generator

This block produces four complementary pulse-width pairs from one shared period counter. The counter counts down from a programmable reload value to zero and then reloads. Each pair owns two active compare values, one that drives its output high and one that drives it low. An edge event is the cycle in which the counter equals one of these values. The true output is registered, so it changes in the cycle after the event. The complementary output is its inverse while the generators run. Both outputs are low while the generators are stopped.

Compare values are written through a single-cycle write port that carries a pair number, an edge selector and a value. While the generators are stopped, a write lands straight in the active compare register. While they run, a write lands in a holding register. A held high-going value moves into service only at that pair's low-going event, and a held low-going value only at the high-going event. This keeps a period from being cut in half by a write that arrives part way through.

A global output stage, active only in multi-output mode, can combine every true output with its own port bit, and separately every complementary output with its own port bit. The combining function is AND or OR, so the pins can be forced low or high while the counter keeps running.

Top module: `mpwm_core`

## Requirements
- R1: While `gen_en` is 1 the period counter steps down by one each cycle and loads `period` in the cycle after it reaches zero. While `gen_en` is 0 it holds at `period`, so the first enabled cycle starts from `period`.
- R2: With the generators running, a cycle in which the counter equals a pair's active high-going value sets that pair's true output in the next cycle. A match with the active low-going value clears it in the next cycle. When both values match in the same cycle, the output is cleared.
- R3: While `gen_en` is 0, with gating off, `pwm_p` and `pwm_n` are all 0. A write (`wr_sel` 0 = high-going value, 1 = low-going value) loads the active register of pair `wr_ch` at once.
- R4: While running, a high-going value write is held. It reaches the active register only at that pair's next low-going event. A later write before that event replaces the held value, and only the latest value is moved.
- R5: While running, a low-going value write is held. It reaches the active register only at that pair's next high-going event.
- R6: When a moved value has already been passed by the counter in the current period, the transition is missed. The output keeps its level through the reload until the counter reaches that value again. With period 15, high-going 12 and a new low-going 13, the true output stays high for 15 consecutive cycles.
- R7: While running, with gating off, `pwm_n` is the bitwise inverse of `pwm_p`.
- R8: With `multi_mode` at 1, `gate_true` = 01 gives `pwm_p` = raw AND `port_true`, and 10 gives raw OR `port_true`. Codes 00 and 11 pass the raw true outputs through. With `multi_mode` at 0, the raw true outputs pass through for every code.
- R9: `gate_comp` applies the same encoding to `pwm_n` using `port_comp`, independently of `gate_true`.
- R10: If a write to a held value arrives in the same cycle as the event that moves that value, the previously held value is moved. The new value stays held until the following event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gen_en | input | 1 | Generators run when 1 |
| multi_mode | input | 1 | Enables the output gating stage |
| period | input | 8 | Counter reload value |
| wr_en | input | 1 | Compare write strobe |
| wr_ch | input | 2 | Pair number of the write |
| wr_sel | input | 1 | 0 = high-going value, 1 = low-going value |
| wr_data | input | 8 | Compare value written |
| gate_true | input | 2 | Gating code for true outputs |
| gate_comp | input | 2 | Gating code for complementary outputs |
| port_true | input | 4 | Port bits combined with the true outputs |
| port_comp | input | 4 | Port bits combined with the complementary outputs |
| pwm_p | output | 4 | True outputs |
| pwm_n | output | 4 | Complementary outputs |

## Verification
A held-value write and the edge event that moves held values can land in the same cycle. The bench provokes this by tracking its own model counter and issuing a new high-going write for pair 1 exactly in the cycle the counter equals that pair's low-going value, while an older write is still held. The judgement is that the older value governs the next period and the new one only the period after. This is compared cycle by cycle against the bench's behavioural model, and the pair's output timing exposes which value was moved.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;
    typedef enum logic [1:0] {
        GM_PASS     = 2'b00,
        GM_AND      = 2'b01,
        GM_OR       = 2'b10,
        GM_PASS_ALT = 2'b11
    } gate_mode_e;

    localparam logic SEL_RISE = 1'b0;
    localparam logic SEL_FALL = 1'b1;
endpackage

// File: rtl/mpwm_period_counter.sv
module mpwm_period_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [CNT_W-1:0] period_i,
    output logic [CNT_W-1:0] count_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run_i) begin
            st_d.cnt = period_i;
        end else if (st_q.cnt == '0) begin
            st_d.cnt = period_i;
        end else begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.cnt;

    assert_reload_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && st_q.cnt == '0) |=> (st_q.cnt == $past(period_i)));
    assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && st_q.cnt != '0) |=> (st_q.cnt == $past(st_q.cnt) - CNT_W'(1)));
    assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i) |=> (st_q.cnt == $past(period_i)));
endmodule

// File: rtl/mpwm_edge_channel.sv
module mpwm_edge_channel
    import mpwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             wr_en_i,
    input  logic             wr_sel_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic             pwm_o
);
    typedef struct packed {
        logic [CNT_W-1:0] rise_act;
        logic [CNT_W-1:0] fall_act;
        logic [CNT_W-1:0] rise_buf;
        logic [CNT_W-1:0] fall_buf;
        logic             rise_pend;
        logic             fall_pend;
        logic             out;
    } chan_state_t;

    chan_state_t st_d, st_q;
    logic rise_ev, fall_ev;

    always_comb begin
        st_d    = st_q;
        rise_ev = run_i && (count_i == st_q.rise_act);
        fall_ev = run_i && (count_i == st_q.fall_act);
        if (!run_i) begin
            st_d.out       = 1'b0;
            st_d.rise_pend = 1'b0;
            st_d.fall_pend = 1'b0;
            if (wr_en_i) begin
                if (wr_sel_i == SEL_FALL) st_d.fall_act = wr_data_i;
                else                      st_d.rise_act = wr_data_i;
            end
        end else begin
            if (fall_ev)      st_d.out = 1'b0;
            else if (rise_ev) st_d.out = 1'b1;
            if (fall_ev && st_q.rise_pend) begin
                st_d.rise_act  = st_q.rise_buf;
                st_d.rise_pend = 1'b0;
            end
            if (rise_ev && st_q.fall_pend) begin
                st_d.fall_act  = st_q.fall_buf;
                st_d.fall_pend = 1'b0;
            end
            if (wr_en_i) begin
                if (wr_sel_i == SEL_FALL) begin
                    st_d.fall_buf  = wr_data_i;
                    st_d.fall_pend = 1'b1;
                end else begin
                    st_d.rise_buf  = wr_data_i;
                    st_d.rise_pend = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pwm_o = st_q.out;

    assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_ev && !fall_ev) |=> st_q.out);
    assert_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fall_ev |=> !st_q.out);
    assert_idle_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !st_q.out);
    assert_direct_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && wr_en_i && wr_sel_i == SEL_RISE) |=> (st_q.rise_act == $past(wr_data_i)));
    assert_rise_xfer_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_ev && st_q.rise_pend) |=> (st_q.rise_act == $past(st_q.rise_buf)));
    assert_rise_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !fall_ev) |=> $stable(st_q.rise_act));
    assert_fall_xfer_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_ev && st_q.fall_pend) |=> (st_q.fall_act == $past(st_q.fall_buf)));
    assert_fall_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !rise_ev) |=> $stable(st_q.fall_act));
    assert_clash_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_ev && st_q.rise_pend && wr_en_i && wr_sel_i == SEL_RISE)
        |=> (st_q.rise_pend && st_q.rise_buf == $past(wr_data_i)));
endmodule

// File: rtl/mpwm_output_gate.sv
module mpwm_output_gate
    import mpwm_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic              multi_i,
    input  logic [1:0]        mode_i,
    input  logic [NUM_CH-1:0] raw_i,
    input  logic [NUM_CH-1:0] port_i,
    output logic [NUM_CH-1:0] out_o
);
    always_comb begin
        out_o = raw_i;
        if (multi_i) begin
            case (gate_mode_e'(mode_i))
                GM_AND:  out_o = raw_i & port_i;
                GM_OR:   out_o = raw_i | port_i;
                default: out_o = raw_i;
            endcase
        end
    end
endmodule

// File: rtl/mpwm_core.sv
module mpwm_core
    import mpwm_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 8,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gen_en,
    input  logic              multi_mode,
    input  logic [CNT_W-1:0]  period,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic              wr_sel,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [1:0]        gate_true,
    input  logic [1:0]        gate_comp,
    input  logic [NUM_CH-1:0] port_true,
    input  logic [NUM_CH-1:0] port_comp,
    output logic [NUM_CH-1:0] pwm_p,
    output logic [NUM_CH-1:0] pwm_n
);
    logic [CNT_W-1:0]  count;
    logic [NUM_CH-1:0] chan_out;
    logic [NUM_CH-1:0] raw_p, raw_n;

    mpwm_period_counter #(.CNT_W(CNT_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (gen_en),
        .period_i (period),
        .count_o  (count)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        mpwm_edge_channel #(.CNT_W(CNT_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .run_i     (gen_en),
            .count_i   (count),
            .wr_en_i   (wr_en && (wr_ch == CH_W'(g))),
            .wr_sel_i  (wr_sel),
            .wr_data_i (wr_data),
            .pwm_o     (chan_out[g])
        );
    end

    assign raw_p = {NUM_CH{gen_en}} & chan_out;
    assign raw_n = {NUM_CH{gen_en}} & ~chan_out;

    mpwm_output_gate #(.NUM_CH(NUM_CH)) u_gate_true (
        .multi_i (multi_mode),
        .mode_i  (gate_true),
        .raw_i   (raw_p),
        .port_i  (port_true),
        .out_o   (pwm_p)
    );

    mpwm_output_gate #(.NUM_CH(NUM_CH)) u_gate_comp (
        .multi_i (multi_mode),
        .mode_i  (gate_comp),
        .raw_i   (raw_n),
        .port_i  (port_comp),
        .out_o   (pwm_n)
    );

    logic gating_off;
    assign gating_off = !multi_mode ||
        ((gate_true != GM_AND) && (gate_true != GM_OR) &&
         (gate_comp != GM_AND) && (gate_comp != GM_OR));

    assert_comp_inverse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_en && gating_off) |-> (pwm_n == ~pwm_p));
    assert_stopped_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!gen_en && gating_off) |-> (pwm_p == '0 && pwm_n == '0));
    assert_and_true_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (multi_mode && gate_true == GM_AND) |-> ((pwm_p & ~port_true) == '0));
    assert_or_true_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (multi_mode && gate_true == GM_OR) |-> ((pwm_p & port_true) == port_true));
    assert_and_comp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (multi_mode && gate_comp == GM_AND) |-> ((pwm_n & ~port_comp) == '0));
    assert_or_comp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (multi_mode && gate_comp == GM_OR) |-> ((pwm_n & port_comp) == port_comp));
endmodule

// File: tb/mpwm_core_tb.sv
module mpwm_core_tb;
    localparam int CYC = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       gen_en = 1'b0, multi_mode = 1'b0;
    logic [7:0] period = 8'd15;
    logic       wr_en = 1'b0, wr_sel = 1'b0;
    logic [1:0] wr_ch = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] gate_true = 2'b00, gate_comp = 2'b00;
    logic [3:0] port_true = '0, port_comp = '0;
    logic [3:0] pwm_p, pwm_n;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    string phase_req = "R3";

    // behavioural reference state
    int m_cnt;
    int m_ra[4], m_fa[4], m_rb[4], m_fb[4];
    bit m_rp[4], m_fp[4], m_out[4];
    int run_len = 0, max_run = 0;

    always #(CYC/2) clk = ~clk;

    mpwm_core u_dut (
        .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .multi_mode(multi_mode),
        .period(period), .wr_en(wr_en), .wr_ch(wr_ch), .wr_sel(wr_sel),
        .wr_data(wr_data), .gate_true(gate_true), .gate_comp(gate_comp),
        .port_true(port_true), .port_comp(port_comp),
        .pwm_p(pwm_p), .pwm_n(pwm_n)
    );

    task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    function automatic logic [3:0] gate_fn(logic m, logic [1:0] code, logic [3:0] raw, logic [3:0] port);
        if (!m) return raw;
        if (code == 2'b01) return raw & port;
        if (code == 2'b10) return raw | port;
        return raw;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0;
            for (int i = 0; i < 4; i++) begin
                m_ra[i] = 0; m_fa[i] = 0; m_rb[i] = 0; m_fb[i] = 0;
                m_rp[i] = 0; m_fp[i] = 0; m_out[i] = 0;
            end
        end else if (!gen_en) begin
            m_cnt = period;
            for (int i = 0; i < 4; i++) begin
                m_out[i] = 0; m_rp[i] = 0; m_fp[i] = 0;
            end
            if (wr_en) begin
                if (wr_sel) m_fa[wr_ch] = wr_data;
                else        m_ra[wr_ch] = wr_data;
            end
        end else begin
            for (int i = 0; i < 4; i++) begin
                bit rev, fev;
                rev = (m_cnt == m_ra[i]);
                fev = (m_cnt == m_fa[i]);
                if (fev) m_out[i] = 0;
                else if (rev) m_out[i] = 1;
                if (fev && m_rp[i]) begin m_ra[i] = m_rb[i]; m_rp[i] = 0; end
                if (rev && m_fp[i]) begin m_fa[i] = m_fb[i]; m_fp[i] = 0; end
            end
            if (wr_en) begin
                if (wr_sel) begin m_fb[wr_ch] = wr_data; m_fp[wr_ch] = 1; end
                else        begin m_rb[wr_ch] = wr_data; m_rp[wr_ch] = 1; end
            end
            m_cnt = (m_cnt == 0) ? int'(period) : m_cnt - 1;
        end
    end

    // compare against the model in the middle of the high phase
    always @(posedge clk) begin
        #5;
        if (rst_n && !done) begin
            logic [3:0] rp, rn;
            for (int i = 0; i < 4; i++) begin
                rp[i] = gen_en & m_out[i];
                rn[i] = gen_en & ~m_out[i];
            end
            chk(phase_req, pwm_p, gate_fn(multi_mode, gate_true, rp, port_true));
            chk(phase_req, pwm_n, gate_fn(multi_mode, gate_comp, rn, port_comp));
            if (phase_req == "R6") begin
                run_len = pwm_p[0] ? run_len + 1 : 0;
                if (run_len > max_run) max_run = run_len;
            end
        end
    end

    task automatic wr_now(int ch, bit sel, int val);
        wr_en = 1'b1; wr_ch = 2'(ch); wr_sel = sel; wr_data = 8'(val);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr(int ch, bit sel, int val);
        @(negedge clk);
        wr_now(ch, sel, val);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * CYC);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        idle(3);
        #1;
        chk("R3 reset p", pwm_p, 4'b0000);
        chk("R3 reset n", pwm_n, 4'b0000);
        rst_n = 1'b1;
        // R3: direct loads while stopped; R2 tie on pair 2
        phase_req = "R3";
        wr(0, 0, 12); wr(0, 1, 4);
        wr(1, 0, 10); wr(1, 1, 2);
        wr(2, 0, 6);  wr(2, 1, 6);
        wr(3, 0, 3);  wr(3, 1, 13);
        idle(3);
        chk("R3 stopped p", pwm_p, 4'b0000);
        chk("R3 stopped n", pwm_n, 4'b0000);
        phase_req = "R2";
        gen_en = 1'b1;
        idle(40);
        phase_req = "R7";
        idle(20);
        phase_req = "R1";
        period = 8'd9;
        idle(30);
        period = 8'd15;
        idle(20);
        // R4: two held writes, latest wins
        phase_req = "R4";
        wr(0, 0, 9); wr(0, 0, 7);
        idle(40);
        phase_req = "R5";
        wr(1, 1, 6);
        idle(40);
        // R10: new write in the exact cycle of the moving event
        phase_req = "R10";
        wr(1, 0, 9);
        do @(negedge clk); while (m_cnt != m_fa[1]);
        wr_now(1, 0, 5);
        idle(50);
        // R6: missed transition holds the level through the reload
        phase_req = "R3";
        @(negedge clk) gen_en = 1'b0;
        wr(0, 0, 12); wr(0, 1, 4);
        @(negedge clk) gen_en = 1'b1;
        idle(20);
        phase_req = "R6";
        max_run = 0; run_len = 0;
        wr(0, 1, 13);
        idle(50);
        n_chk++;
        if (max_run != 15) begin
            n_fail++;
            $display("FAIL R6 high run actual=%0d expected=15", max_run);
        end
        // R8: true output gating
        phase_req = "R8";
        @(negedge clk);
        multi_mode = 1'b1; port_true = 4'b0101; gate_true = 2'b01;
        idle(20);
        gate_true = 2'b10; idle(20);
        gate_true = 2'b11; idle(20);
        multi_mode = 1'b0; gate_true = 2'b01; idle(20);
        gate_true = 2'b00;
        // R9: complementary gating, independent code
        phase_req = "R9";
        multi_mode = 1'b1; port_comp = 4'b0011; gate_comp = 2'b01;
        idle(20);
        gate_comp = 2'b10; idle(20);
        gate_comp = 2'b00; gate_true = 2'b10; idle(20);
        @(negedge clk);
        finish_run();
    end
endmodule